// File: doc/BRIEF.md
# Register Rename Map Unit

This unit renames registers for an out-of-order core. Each architectural register name is bound to a physical tag. Every cycle the unit accepts at most one decoded instruction. That instruction carries two source names and an optional destination name. The unit returns the physical tags of both sources. It also returns the tag that the destination held until now, so that tag can be released when the instruction retires. If the instruction overwrites its destination, the unit binds that destination to a fresh tag taken from a circular free list. Because later readers follow the new tag, two instructions that fully overwrite the same name carry no dependency on each other. A narrow write, which leaves part of the old value in place, also gets a fresh tag. It is flagged as reading the previous tag as well, so the untouched bits can be merged.

A plain register-to-register move takes no tag from the list. The destination is bound to the source's tag, and a per-tag reference count records how many names share that tag. The retire port hands back previous tags. A tag goes back to the tail of the free list only when its last reference is dropped.

The free list is governed by a two-state machine. In FL_HAS_FREE at least one tag is available. The transition to FL_DRAINED is taken when the last free tag is popped in a cycle with no release. The transition back to FL_HAS_FREE is taken in any cycle that releases a tag. In FL_DRAINED, any instruction that needs a new tag is stalled.

Top module: `rmu_rename`

## Requirements
- R1: After reset, architectural register i maps to tag i. The free list holds tags NUM_ARCH to NUM_PHYS-1 in ascending order, so the first allocation receives tag NUM_ARCH.
- R2: ren_tag_a and ren_tag_b give the current bindings of ren_src_a and ren_src_b. A destination update made in the same cycle is not visible to the sources until the next cycle, so r1 = r1 + r2 reads the old tag of r1.
- R3: An accepted instruction with ren_dst_we=1 and ren_move=0 receives the head of the free list on ren_new_tag. From the next cycle ren_dst maps to that tag. ren_prev_tag always gives the binding ren_dst held before the update.
- R4: ren_merge_dep is 1 exactly when ren_valid=1, ren_dst_we=1, ren_partial=1 and ren_move=0. Such a partial write still allocates a fresh tag. A full write gives ren_merge_dep=0.
- R5: With ren_move=1 and ren_dst_we=1, no tag leaves the free list. ren_new_tag equals the source tag of ren_src_a, and ren_dst maps to that tag from the next cycle.
- R6: ren_stall is 1 exactly when ren_valid=1, ren_dst_we=1, ren_move=0 and the free list is empty. A stalled instruction changes no binding and takes no tag.
- R7: A retire (cmt_valid=1) drops one reference to cmt_tag. The tag is appended to the tail of the free list only when its last reference is dropped, and released tags are reallocated in FIFO order.
- R8: An allocation and a retire in the same cycle both take effect. When the list is empty, a tag released in a cycle can be allocated in the following cycle.
- R9: An instruction with ren_dst_we=0 changes no binding and takes no tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_src_a | input | ARCH_W | First source name |
| ren_src_b | input | ARCH_W | Second source name |
| ren_dst | input | ARCH_W | Destination name |
| ren_dst_we | input | 1 | The instruction writes ren_dst |
| ren_partial | input | 1 | Narrow write that keeps the other bits |
| ren_move | input | 1 | Eliminated move from ren_src_a to ren_dst |
| cmt_valid | input | 1 | A retired instruction frees a previous tag |
| cmt_tag | input | TAG_W | Previous tag being freed |
| ren_stall | output | 1 | Instruction held back: no free tag |
| ren_tag_a | output | TAG_W | Tag of ren_src_a |
| ren_tag_b | output | TAG_W | Tag of ren_src_b |
| ren_prev_tag | output | TAG_W | Binding of ren_dst before this instruction |
| ren_new_tag | output | TAG_W | Tag bound to ren_dst by this instruction |
| ren_merge_dep | output | 1 | Instruction also depends on ren_prev_tag |

## Verification
The two functions that meet in one cycle are allocation at the head of the free list and release at its tail through the retire port. The bench provokes this by draining the list completely and then retiring tags while allocating in the same cycles. It also mixes both functions in a long seeded random run with retires interleaved. A reference model decides each cycle which tag should come out next and whether a stall is due, and every output is compared against it.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
    typedef enum logic [0:0] {
        FL_HAS_FREE = 1'b0,
        FL_DRAINED  = 1'b1
    } fl_state_e;
endpackage

// File: rtl/rmu_free_list.sv
module rmu_free_list
    import rmu_pkg::*;
#(
    parameter int NUM_PHYS = 120,
    parameter int NUM_ARCH = 16,
    parameter int TAG_W    = $clog2(NUM_PHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_en,
    input  logic             push_en,
    input  logic [TAG_W-1:0] push_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty
);
    localparam int PTR_W     = $clog2(NUM_PHYS);
    localparam int CNT_W     = $clog2(NUM_PHYS + 1);
    localparam int INIT_FREE = NUM_PHYS - NUM_ARCH;

    logic [TAG_W-1:0] slots [NUM_PHYS];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q, count_nx;
    fl_state_e        state_q, state_nx;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign count_nx = count_q + CNT_W'(push_en) - CNT_W'(pop_en);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= (INIT_FREE > 0) ? FL_HAS_FREE : FL_DRAINED;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FL_HAS_FREE: if (count_nx == '0) state_nx = FL_DRAINED;
            FL_DRAINED:  if (push_en)        state_nx = FL_HAS_FREE;
            default:     state_nx = FL_DRAINED;
        endcase
    end

    // outputs
    always_comb begin
        empty    = (state_q == FL_DRAINED);
        head_tag = slots[head_q];
    end

    // storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++)
                slots[i] <= (i < INIT_FREE) ? TAG_W'(NUM_ARCH + i) : '0;
            head_q  <= '0;
            tail_q  <= PTR_W'(INIT_FREE % NUM_PHYS);
            count_q <= CNT_W'(INIT_FREE);
        end else begin
            if (push_en) begin
                slots[tail_q] <= push_tag;
                tail_q        <= bump(tail_q);
            end
            if (pop_en) head_q <= bump(head_q);
            count_q <= count_nx;
        end
    end

    a_r6_no_pop_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (state_q == FL_HAS_FREE));
    a_r8_push_pop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && push_en) |=> (count_q == $past(count_q)));
    a_r1_count_within_pool: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(NUM_PHYS));
endmodule

// File: rtl/rmu_map_table.sv
module rmu_map_table #(
    parameter int NUM_ARCH = 16,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int TAG_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARCH_W-1:0] rd_a,
    input  logic [ARCH_W-1:0] rd_b,
    input  logic [ARCH_W-1:0] rd_d,
    output logic [TAG_W-1:0]  tag_a,
    output logic [TAG_W-1:0]  tag_b,
    output logic [TAG_W-1:0]  tag_d,
    input  logic              we,
    input  logic [ARCH_W-1:0] wa,
    input  logic [TAG_W-1:0]  wtag
);
    logic [TAG_W-1:0] binding [NUM_ARCH];

    // reads see the state before this cycle's write
    assign tag_a = binding[rd_a];
    assign tag_b = binding[rd_b];
    assign tag_d = binding[rd_d];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) binding[i] <= TAG_W'(i);
        end else if (we) begin
            binding[wa] <= wtag;
        end
    end

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (binding[$past(wa)] == $past(wtag)));
endmodule

// File: rtl/rmu_ref_count.sv
module rmu_ref_count #(
    parameter int NUM_PHYS = 120,
    parameter int NUM_ARCH = 16,
    parameter int TAG_W    = $clog2(NUM_PHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [TAG_W-1:0] inc_tag,
    input  logic             dec_en,
    input  logic [TAG_W-1:0] dec_tag,
    output logic             release_tag
);
    localparam int CW = $clog2(NUM_ARCH + 2);

    logic [CW-1:0] refs [NUM_PHYS];

    for (genvar g = 0; g < NUM_PHYS; g++) begin : g_ctr
        logic inc_hit, dec_hit;
        assign inc_hit = inc_en && (inc_tag == TAG_W'(g));
        assign dec_hit = dec_en && (dec_tag == TAG_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) refs[g] <= (g < NUM_ARCH) ? CW'(1) : '0;
            else if (inc_hit && !dec_hit) refs[g] <= refs[g] + 1'b1;
            else if (dec_hit && !inc_hit) refs[g] <= refs[g] - 1'b1;
        end
    end

    assign release_tag = dec_en && (refs[dec_tag] == CW'(1))
                      && !(inc_en && (inc_tag == dec_tag));

    a_r7_no_dec_of_free_tag: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> (refs[dec_tag] != '0));
endmodule

// File: rtl/rmu_rename.sv
module rmu_rename #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 120,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int TAG_W    = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [ARCH_W-1:0] ren_src_a,
    input  logic [ARCH_W-1:0] ren_src_b,
    input  logic [ARCH_W-1:0] ren_dst,
    input  logic              ren_dst_we,
    input  logic              ren_partial,
    input  logic              ren_move,
    input  logic              cmt_valid,
    input  logic [TAG_W-1:0]  cmt_tag,
    output logic              ren_stall,
    output logic [TAG_W-1:0]  ren_tag_a,
    output logic [TAG_W-1:0]  ren_tag_b,
    output logic [TAG_W-1:0]  ren_prev_tag,
    output logic [TAG_W-1:0]  ren_new_tag,
    output logic              ren_merge_dep
);
    logic             fl_empty, fl_pop, fl_push;
    logic [TAG_W-1:0] fl_head;
    logic             needs_tag, do_alloc, do_move, map_we;
    logic [TAG_W-1:0] map_wtag;

    assign needs_tag     = ren_valid && ren_dst_we && !ren_move;
    assign ren_stall     = needs_tag && fl_empty;
    assign do_alloc      = needs_tag && !fl_empty;
    assign do_move       = ren_valid && ren_dst_we && ren_move;
    assign map_we        = do_alloc || do_move;
    assign map_wtag      = ren_move ? ren_tag_a : fl_head;
    assign fl_pop        = do_alloc;
    assign ren_new_tag   = map_wtag;
    assign ren_merge_dep = needs_tag && ren_partial;

    rmu_map_table #(.NUM_ARCH(NUM_ARCH), .ARCH_W(ARCH_W), .TAG_W(TAG_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd_a(ren_src_a), .rd_b(ren_src_b), .rd_d(ren_dst),
        .tag_a(ren_tag_a), .tag_b(ren_tag_b), .tag_d(ren_prev_tag),
        .we(map_we), .wa(ren_dst), .wtag(map_wtag)
    );

    rmu_ref_count #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_refs (
        .clk(clk), .rst_n(rst_n),
        .inc_en(map_we), .inc_tag(map_wtag),
        .dec_en(cmt_valid), .dec_tag(cmt_tag),
        .release_tag(fl_push)
    );

    rmu_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop_en(fl_pop), .push_en(fl_push), .push_tag(cmt_tag),
        .head_tag(fl_head), .empty(fl_empty)
    );

    a_r6_stall_only_for_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |-> (ren_valid && ren_dst_we && !ren_move));
endmodule

// File: tb/rmu_rename_tb.sv
module rmu_rename_tb;
    localparam int CLK_P    = 10;
    localparam int NUM_ARCH = 16;
    localparam int NUM_PHYS = 120;
    localparam int ARCH_W   = $clog2(NUM_ARCH);
    localparam int TAG_W    = $clog2(NUM_PHYS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ren_valid = 1'b0, ren_dst_we = 1'b0, ren_partial = 1'b0, ren_move = 1'b0;
    logic [ARCH_W-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic cmt_valid = 1'b0;
    logic [TAG_W-1:0] cmt_tag = '0;
    logic ren_stall, ren_merge_dep;
    logic [TAG_W-1:0] ren_tag_a, ren_tag_b, ren_prev_tag, ren_new_tag;

    always #(CLK_P/2) clk = ~clk;

    rmu_rename #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_dst(ren_dst), .ren_dst_we(ren_dst_we), .ren_partial(ren_partial),
        .ren_move(ren_move), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
        .ren_stall(ren_stall), .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b),
        .ren_prev_tag(ren_prev_tag), .ren_new_tag(ren_new_tag),
        .ren_merge_dep(ren_merge_dep)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    int mdl_map [NUM_ARCH];
    int mdl_refs [NUM_PHYS];
    int mdl_free [$];
    int mdl_pend [$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_stall(input bit v, input bit we, input bit mv);
        return v && we && !mv && (mdl_free.size() == 0);
    endfunction

    // one cycle: drive at negedge, compare before posedge, advance the model
    task automatic step(input string req, input bit v, input int a, input int b, input int d,
                        input bit we, input bit pt, input bit mv, input bit cv);
        int ct, wt;
        bit st, do_cmt;
        @(negedge clk);
        do_cmt = cv && (mdl_pend.size() > 0);
        ct = do_cmt ? mdl_pend.pop_front() : 0;
        ren_valid = v; ren_src_a = ARCH_W'(a); ren_src_b = ARCH_W'(b); ren_dst = ARCH_W'(d);
        ren_dst_we = we; ren_partial = pt; ren_move = mv;
        cmt_valid = do_cmt; cmt_tag = TAG_W'(ct);
        #1;
        st = exp_stall(v, we, mv);
        chk(req, "tag_a", int'(ren_tag_a), mdl_map[a]);
        chk(req, "tag_b", int'(ren_tag_b), mdl_map[b]);
        chk(req, "prev_tag", int'(ren_prev_tag), mdl_map[d]);
        chk(req, "stall", int'(ren_stall), int'(st));
        chk(req, "merge_dep", int'(ren_merge_dep), int'(v && we && pt && !mv));
        if (mv) chk(req, "new_tag(move)", int'(ren_new_tag), mdl_map[a]);
        else if (mdl_free.size() > 0) chk(req, "new_tag", int'(ren_new_tag), mdl_free[0]);
        if (v && we && !st) begin
            wt = mv ? mdl_map[a] : mdl_free.pop_front();
            mdl_refs[wt]++;
            mdl_pend.push_back(mdl_map[d]);
            mdl_map[d] = wt;
        end
        if (do_cmt) begin
            mdl_refs[ct]--;
            if (mdl_refs[ct] == 0) mdl_free.push_back(ct);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int drain_d;
        void'($urandom(32'd4242));
        for (int i = 0; i < NUM_ARCH; i++) mdl_map[i] = i;
        for (int i = 0; i < NUM_PHYS; i++) mdl_refs[i] = (i < NUM_ARCH) ? 1 : 0;
        for (int i = NUM_ARCH; i < NUM_PHYS; i++) mdl_free.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset bindings and first free tag
        for (int i = 0; i < NUM_ARCH; i++) begin
            step("R1", 0, i, NUM_ARCH - 1 - i, 0, 0, 0, 0, 0);
            chk("R1", "reset tag_a", int'(ren_tag_a), i);
        end
        chk("R1", "first free", int'(ren_new_tag), NUM_ARCH);

        // R2: r1 = r1 + r2 reads the old tag of r1
        step("R2", 1, 1, 2, 1, 1, 0, 0, 0);
        chk("R2", "old src tag", int'(ren_tag_a), 1);
        chk("R3", "alloc head", int'(ren_new_tag), 16);
        step("R3", 0, 1, 2, 0, 0, 0, 0, 0);
        chk("R3", "binding updated", int'(ren_tag_a), 16);

        // R4: partial write flags merge, full write does not
        step("R4", 1, 0, 0, 3, 1, 1, 0, 0);
        chk("R4", "merge_dep", int'(ren_merge_dep), 1);
        chk("R4", "prev", int'(ren_prev_tag), 3);
        step("R4", 1, 0, 0, 4, 1, 0, 0, 0);
        chk("R4", "full merge_dep", int'(ren_merge_dep), 0);
        chk("R4", "new", int'(ren_new_tag), 18);

        // R5: move shares the tag and leaves the list alone
        step("R5", 1, 1, 0, 5, 1, 0, 1, 0);
        chk("R5", "move tag", int'(ren_new_tag), 16);
        step("R5", 0, 5, 0, 0, 0, 0, 0, 0);
        chk("R5", "moved binding", int'(ren_tag_a), 16);
        step("R5", 1, 0, 0, 6, 1, 0, 0, 0);
        chk("R5", "list not popped", int'(ren_new_tag), 19);

        // R9: no destination write
        step("R9", 1, 0, 0, 7, 0, 0, 0, 0);
        step("R9", 0, 7, 0, 0, 0, 0, 0, 0);
        chk("R9", "binding kept", int'(ren_tag_a), 7);
        chk("R9", "no tag taken", int'(ren_new_tag), 20);

        // R6: drain the pool, then stall
        drain_d = 8;
        while (mdl_free.size() > 0) begin
            step("R3", 1, 0, 0, drain_d, 1, 0, 0, 0);
            drain_d = (drain_d == 15) ? 8 : drain_d + 1;
        end
        step("R6", 1, 0, 0, 9, 1, 0, 0, 0);
        chk("R6", "stall when empty", int'(ren_stall), 1);
        step("R6", 0, 9, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 2, 0, 10, 1, 0, 1, 0);
        chk("R6", "move not stalled", int'(ren_stall), 0);
        step("R9", 1, 2, 0, 11, 0, 0, 0, 0);
        chk("R9", "no-dest not stalled", int'(ren_stall), 0);

        // R7/R8: release while empty, then allocate and release together
        step("R7", 0, 0, 0, 0, 0, 0, 0, 1);
        step("R8", 1, 0, 0, 12, 1, 0, 0, 1);
        chk("R8", "released tag reused", int'(ren_new_tag), 1);
        chk("R8", "no stall", int'(ren_stall), 0);
        step("R8", 0, 12, 0, 0, 0, 0, 0, 0);
        chk("R8", "both took effect", int'(ren_new_tag), 3);
        chk("R8", "dst bound", int'(ren_tag_a), 1);

        // random mix of renames, moves and retires
        for (int k = 0; k < 4000; k++) begin
            bit v, we, pt, mv, cv;
            v  = ($urandom_range(0, 99) < 75);
            we = ($urandom_range(0, 99) < 85);
            pt = ($urandom_range(0, 99) < 20);
            mv = ($urandom_range(0, 99) < 15);
            cv = ($urandom_range(0, 99) < ((k / 500) % 2 == 0 ? 40 : 75));
            step("R7", v, $urandom_range(0, NUM_ARCH - 1), $urandom_range(0, NUM_ARCH - 1),
                 $urandom_range(0, NUM_ARCH - 1), we, pt, mv, cv);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule